// File: doc/BRIEF.md
# Interrupt-Return Flags Merge Unit

This block holds the processor flags register and updates it when an interrupt return commits. It takes the flags image popped from the stack. It also takes the privilege level that was in effect before the return, the operand size and a long-mode indicator. From these it builds a write mask that says which flag bits the image may overwrite. The bits the mask leaves closed keep the value they already had in the register. The I/O privilege level used for the interrupt-enable rule is read from the register's own field.

The merged value is written into the register only on the cycle the update strobe is high. In every other cycle the register holds. A CPU-generation parameter controls whether the alignment-check and identification bits can be written outside long mode. Reserved bits are always forced to their fixed values when the register is written.

Top module: `rflags_merge`

## Requirements
- R1: After reset the flags register reads 0x00000002.
- R2: On an update, CF(0), PF(2), AF(4), ZF(6), SF(7), TF(8), DF(10), OF(11), NT(14) and RF(16) take the popped value, whatever the privilege level. Bits 16 and up are subject to R6.
- R3: AC(18) and ID(21) take the popped value when GEN_LEVEL is 4 or more, or when long_i is 1. Otherwise they keep their old value.
- R4: IF(9) takes the popped value only when prev_cpl_i is less than or equal to the current IOPL field (bits 13:12 of the register). Otherwise IF keeps its old value.
- R5: VIF(19), VIP(20) and IOPL(13:12) take the popped value only when prev_cpl_i is 0.
- R6: When op_size_i is 2'b00 (16-bit), bits 31:16 keep their old value. 2'b01 selects 32-bit and 2'b10 selects 64-bit; both open the full mask.
- R7: VM(17) is never changed by an update. The popped VM bit is ignored in both legacy and long mode.
- R8: After every update, bit 1 reads 1 and bits 3, 5 and 15 read 0, whatever was popped.
- R9: While upd_i is 0 the register holds its value, whatever the other inputs do.
- R10: Bits 31:22 are never changed by an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Commit strobe for the merged flags |
| popped_i | input | 32 | Flags image popped by the return |
| prev_cpl_i | input | 2 | Privilege level before the return |
| op_size_i | input | 2 | Operand size: 00 = 16, 01 = 32, 10 = 64 |
| long_i | input | 1 | Long mode active |
| flags_o | output | 32 | Flags register |

## Verification
The merge is driven with all-ones and all-zeros images at privilege levels 0, 1, 2 and 3. The register is first raised to IOPL 3 and later lowered to IOPL 0. This separates the IF rule, which compares against IOPL, from the VIF/VIP/IOPL rule, which needs level 0. Returns with the same images at 16-bit and at 32-bit size show whether the upper half is protected. A second instance built for generation 3 receives the same image with long mode off and then on, which isolates the AC/ID condition. An image with VM, the reserved low bits and the upper reserved bits set shows that none of them gets through. A stretch of changing inputs with the strobe low shows that the register holds.

// File: rtl/rflags_pkg.sv
package rflags_pkg;
  localparam int FLAG_W = 32;

  localparam int B_CF   = 0;
  localparam int B_RS1  = 1;
  localparam int B_PF   = 2;
  localparam int B_RS3  = 3;
  localparam int B_AF   = 4;
  localparam int B_RS5  = 5;
  localparam int B_ZF   = 6;
  localparam int B_SF   = 7;
  localparam int B_TF   = 8;
  localparam int B_IF   = 9;
  localparam int B_DF   = 10;
  localparam int B_OF   = 11;
  localparam int B_IOPL = 12;
  localparam int B_NT   = 14;
  localparam int B_RS15 = 15;
  localparam int B_RF   = 16;
  localparam int B_VM   = 17;
  localparam int B_AC   = 18;
  localparam int B_VIF  = 19;
  localparam int B_VIP  = 20;
  localparam int B_ID   = 21;

  localparam logic [FLAG_W-1:0] RESET_VAL = 32'h0000_0002;

  typedef enum logic [1:0] {
    OSZ_16 = 2'b00,
    OSZ_32 = 2'b01,
    OSZ_64 = 2'b10
  } osz_e;
endpackage

// File: rtl/rflags_mask_gen.sv
module rflags_mask_gen
  import rflags_pkg::*;
#(
  parameter int GEN_LEVEL = 6
) (
  input  logic [1:0]        prev_cpl_i,
  input  logic [1:0]        iopl_i,
  input  logic [1:0]        op_size_i,
  input  logic              long_i,
  output logic [FLAG_W-1:0] mask_o
);
  localparam int HALF_W = FLAG_W / 2;
  localparam bit GEN_HAS_ACID = (GEN_LEVEL >= 4);

  logic [FLAG_W-1:0] base_m;
  logic [FLAG_W-1:0] acid_m;
  logic [FLAG_W-1:0] if_m;
  logic [FLAG_W-1:0] priv_m;
  logic [FLAG_W-1:0] full_m;

  always_comb begin
    base_m = '0;
    base_m[B_CF] = 1'b1;
    base_m[B_PF] = 1'b1;
    base_m[B_AF] = 1'b1;
    base_m[B_ZF] = 1'b1;
    base_m[B_SF] = 1'b1;
    base_m[B_TF] = 1'b1;
    base_m[B_DF] = 1'b1;
    base_m[B_OF] = 1'b1;
    base_m[B_NT] = 1'b1;
    base_m[B_RF] = 1'b1;
  end

  generate
    if (GEN_HAS_ACID) begin : g_acid_always
      always_comb begin
        acid_m = '0;
        acid_m[B_AC] = 1'b1;
        acid_m[B_ID] = 1'b1;
      end
    end else begin : g_acid_long
      always_comb begin
        acid_m = '0;
        acid_m[B_AC] = long_i;
        acid_m[B_ID] = long_i;
      end
    end
  endgenerate

  always_comb begin
    if_m = '0;
    if_m[B_IF] = (prev_cpl_i <= iopl_i);
    priv_m = '0;
    priv_m[B_VIP]      = (prev_cpl_i == 2'd0);
    priv_m[B_VIF]      = (prev_cpl_i == 2'd0);
    priv_m[B_IOPL]     = (prev_cpl_i == 2'd0);
    priv_m[B_IOPL + 1] = (prev_cpl_i == 2'd0);
  end

  always_comb begin
    full_m = base_m | acid_m | if_m | priv_m;
    if (op_size_i == OSZ_16) begin
      mask_o = {{(FLAG_W - HALF_W){1'b0}}, full_m[HALF_W-1:0]};
    end else begin
      mask_o = full_m;
    end
  end
endmodule

// File: rtl/rflags_combine.sv
module rflags_combine
  import rflags_pkg::*;
(
  input  logic [FLAG_W-1:0] popped_i,
  input  logic [FLAG_W-1:0] cur_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic              long_i,
  output logic [FLAG_W-1:0] merged_o
);
  logic [FLAG_W-1:0] image;
  logic [FLAG_W-1:0] raw;

  always_comb begin
    image = popped_i;
    if (long_i) begin
      image[B_VM] = 1'b0;
    end
    raw = (image & mask_i) | (cur_i & ~mask_i);
    merged_o = raw;
    merged_o[B_RS1]  = 1'b1;
    merged_o[B_RS3]  = 1'b0;
    merged_o[B_RS5]  = 1'b0;
    merged_o[B_RS15] = 1'b0;
  end
endmodule

// File: rtl/rflags_merge.sv
module rflags_merge
  import rflags_pkg::*;
#(
  parameter int GEN_LEVEL = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [31:0]       popped_i,
  input  logic [1:0]        prev_cpl_i,
  input  logic [1:0]        op_size_i,
  input  logic              long_i,
  output logic [31:0]       flags_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic [FLAG_W-1:0] mask;
  logic [FLAG_W-1:0] merged;

  rflags_mask_gen #(.GEN_LEVEL(GEN_LEVEL)) u_mask (
    .prev_cpl_i (prev_cpl_i),
    .iopl_i     (flags_q[B_IOPL+1:B_IOPL]),
    .op_size_i  (op_size_i),
    .long_i     (long_i),
    .mask_o     (mask)
  );

  rflags_combine u_comb (
    .popped_i (popped_i),
    .cur_i    (flags_q),
    .mask_i   (mask),
    .long_i   (long_i),
    .merged_o (merged)
  );

  always_comb begin
    flags_d = flags_q;
    if (upd_i) begin
      flags_d = merged;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= RESET_VAL;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  a_r4_if_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (prev_cpl_i > flags_o[B_IOPL+1:B_IOPL])) |=> $stable(flags_o[B_IF]));

  a_r5_priv_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (prev_cpl_i != 2'd0)) |=>
      ($stable(flags_o[B_VIP:B_VIF]) && $stable(flags_o[B_IOPL+1:B_IOPL])));

  a_r6_upper_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (op_size_i == OSZ_16)) |=> $stable(flags_o[FLAG_W-1:FLAG_W/2]));

  a_r7_vm_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> $stable(flags_o[B_VM]));

  a_r8_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[B_RS1] && !flags_o[B_RS3] && !flags_o[B_RS5] && !flags_o[B_RS15]));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));

  a_r10_top_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> $stable(flags_o[FLAG_W-1:B_ID+1]));
endmodule

// File: tb/test_rflags_merge.sv
module test_rflags_merge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd;
  logic [31:0] pop;
  logic [1:0]  cpl;
  logic [1:0]  osz;
  logic        lng;
  logic [31:0] flags;
  logic [31:0] flags_g3;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rflags_merge i_rflags_merge (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .popped_i(pop),
    .prev_cpl_i(cpl), .op_size_i(osz), .long_i(lng), .flags_o(flags)
  );

  rflags_merge #(.GEN_LEVEL(3)) i_rflags_merge_g3 (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .popped_i(pop),
    .prev_cpl_i(cpl), .op_size_i(osz), .long_i(lng), .flags_o(flags_g3)
  );

  // {popped[68:37], cpl[36:35], osz[34:33], long[32], expected[31:0]}
  localparam logic [68:0] VEC [8] = '{
    {32'hFFFF_FFFF, 2'd0, 2'b01, 1'b0, 32'h003D_7FD7}, // R2 R5: full open, IOPL->3
    {32'h0000_0000, 2'd3, 2'b01, 1'b0, 32'h0018_3002}, // R4 IF open at cpl3<=3, R5 kept
    {32'hFFFF_FFFF, 2'd3, 2'b00, 1'b0, 32'h0018_7FD7}, // R6 upper half kept
    {32'h0000_0000, 2'd0, 2'b00, 1'b0, 32'h0018_0002}, // R5 IOPL->0, R6
    {32'hFFFF_FFFF, 2'd2, 2'b01, 1'b0, 32'h003D_4DD7}, // R4 IF closed, R3 AC/ID open
    {32'h0002_0000, 2'd0, 2'b10, 1'b1, 32'h0000_0002}, // R7 VM ignored in long mode
    {32'h0024_0000, 2'd1, 2'b01, 1'b1, 32'h0024_0002}, // R3 AC/ID set, R5 closed
    {32'hFFC2_802A, 2'd0, 2'b01, 1'b0, 32'h0000_0002}  // R7 R8 R10 nothing leaks
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] p, input logic [1:0] c, input logic [1:0] s, input logic l);
    @(negedge clk);
    pop = p; cpl = c; osz = s; lng = l; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; upd = 1'b0; pop = '0; cpl = '0; osz = 2'b01; lng = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", flags, 32'h0000_0002);
    check("R1 reset gen3", flags_g3, 32'h0000_0002);

    for (int k = 0; k < 8; k++) begin
      step(VEC[k][68:37], VEC[k][36:35], VEC[k][34:33], VEC[k][32]);
      check($sformatf("row %0d (R2 R3 R4 R5 R6 R7 R8 R10)", k), flags, VEC[k][31:0]);
    end

    // R9: strobe low, inputs changing
    do_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pop = 32'hFFFF_FFFF ^ k; cpl = 2'd0; osz = 2'b01; lng = k[0];
    end
    @(negedge clk);
    check("R9 hold", flags, 32'h0000_0002);

    // R3: generation 3 only opens AC/ID in long mode
    step(32'hFFFF_FFFF, 2'd0, 2'b01, 1'b0);
    check("R3 gen3 legacy", flags_g3, 32'h0019_7FD7);
    check("R3 gen6 legacy", flags, 32'h003D_7FD7);
    step(32'hFFFF_FFFF, 2'd0, 2'b01, 1'b1);
    check("R3 gen3 long", flags_g3, 32'h003D_7FD7);

    // R4: boundary prev_cpl == IOPL (IOPL=3 now) and prev_cpl above IOPL
    step(32'h0000_0000, 2'd0, 2'b01, 1'b0);  // clears all, IOPL->0
    check("R4 prep", flags, 32'h0000_0002);
    step(32'h0000_1200, 2'd0, 2'b01, 1'b0);  // IF=1, IOPL=1
    check("R4 set", flags, 32'h0000_1202);
    step(32'h0000_0000, 2'd1, 2'b01, 1'b0);  // cpl1 == IOPL1 -> IF cleared
    check("R4 equal", flags, 32'h0000_1002);
    step(32'h0000_0200, 2'd2, 2'b01, 1'b0);  // cpl2 > IOPL1 -> IF kept 0
    check("R4 above", flags, 32'h0000_1002);

    finish_run();
  end

  initial begin
    #2000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule